// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host read fixed configuration items, one item at a time, through a small register window. The host first writes a 16-bit key. The key chooses an item from one of two banks: a common bank and an architecture-local bank. Writing the key sets the byte cursor back to the start of the item. Each later data read returns the next bytes of that item and moves the cursor forward by the number of bytes delivered. The item contents are constant tables built at elaboration from the block's parameters. Entry 0 of the common bank holds an ASCII signature and entry 1 holds a version word.

Two address maps can be chosen at build time. The split map has a control register at address 0, which takes key writes, and a data register at address 1, which takes data reads of 1 to 8 bytes. The combined map is a single port: the access width decides whether an access reaches the key or the data. Read data is returned combinationally in the same cycle as the strobe. Key and cursor changes are registered at the clock edge.

Top module: `cfg_item_port`

## Requirements
- R1: After reset, the key is 0, the cursor is 0 and the entry is valid. A 4-byte split-map data read then returns the signature 0x43464750 ("CFGP").
- R2: Every accepted key write sets the cursor to 0, whatever the key value.
- R3: Key bit 15 selects the architecture-local bank (1) or the common bank (0). Bits [13:0] give the entry index. Bit 14 is ignored.
- R4: A key whose index [13:0] is at or above NUM_ENTRIES makes the entry invalid. Every data read then returns 0 until a valid key is written.
- R5: A data read of N bytes (N = 1..8) places the item byte at the cursor in the most significant of the low N bytes, and the following bytes in the lanes below it. The cursor then advances by N.
- R6: If the item ends partway through a read, the unfilled low-order lanes read as zero and the cursor stops at the item length.
- R7: A data read when the cursor is at the item length, or on an empty item (length 0), returns 0 and leaves the cursor unchanged.
- R8: A write to the data register changes neither the key, the cursor nor the data seen by later reads.
- R9: In the split map, address 0 accepts only 2-byte writes as key loads; every other access there is ignored and reads 0. In the combined map, a 1-byte read is a data read, a 2-byte write loads the key, and every other access is ignored and reads 0.
- R10: Common-bank entry 1 is 4 bytes long. Byte 0 has bit 0 set and bit 1 equal to DMA_PRESENT. Bytes 1 to 3 are zero.
- R11: Every other entry (bank b, index i) has length (5*i + 12*b) mod (MAX_LEN+1). Its byte k is ((i<<4) XOR 7k XOR (b ? 0xA5 : 0)), truncated to 8 bits.
- R12: rd_data is zero in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | Split map: 0 = control (key), 1 = data; ignored in the combined map |
| acc_size | input | 4 | Access width in bytes (1..8) |
| acc_wdata | input | 64 | Write data; a key is taken from bits [15:0] |
| rd_data | output | 64 | Read data, valid in the cycle of the strobe |

## Verification
Read data depends only on the registered key and cursor, so each read result is due in the same cycle as its strobe. The bench drives each access at the falling edge and samples rd_data one nanosecond before the next rising edge. Key and cursor updates take effect at that rising edge and so appear only in the following access. The bench's reference model therefore updates its own cursor after each comparison, never before it. Effects that the ports cannot show directly, such as a cleared or unchanged cursor, are checked through the bytes returned by the next data read.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned KEY_W     = 16;
  localparam int unsigned IDX_W     = 14;
  localparam int unsigned BANK_BIT  = 15;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned LANES     = 8;

  // Length of an item in bytes; entries 0 and 1 of the common bank are fixed at 4.
  function automatic int unsigned item_len_f(input int unsigned bank,
                                             input int unsigned idx,
                                             input int unsigned max_len);
    if (bank == 0 && idx < 2) return 4;
    return (idx * 5 + bank * 12) % (max_len + 1);
  endfunction

  // Content byte k of an item.
  function automatic logic [7:0] item_byte_f(input int unsigned bank,
                                             input int unsigned idx,
                                             input int unsigned k,
                                             input bit          dma);
    if (bank == 0 && idx == 0) begin
      case (k)
        0:       return 8'h43;
        1:       return 8'h46;
        2:       return 8'h47;
        default: return 8'h50;
      endcase
    end
    if (bank == 0 && idx == 1) return (k == 0) ? {6'b0, dma, 1'b1} : 8'h00;
    return 8'((idx << 4) ^ (k * 7) ^ ((bank != 0) ? 32'hA5 : 32'h0));
  endfunction
endpackage

// File: rtl/cfg_item_rom.sv
module cfg_item_rom
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned MAX_LEN     = 16,
  parameter bit          DMA_PRESENT = 1'b1,
  parameter int unsigned IDXW        = 3,
  parameter int unsigned OFFW        = 5
) (
  input  logic                   bank_i,
  input  logic [IDXW-1:0]        idx_i,
  input  logic [OFFW-1:0]        off_i,
  output logic [OFFW-1:0]        len_o,
  output logic [LANES-1:0][7:0]  lane_o
);
  localparam int unsigned ADRW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [7:0]      mem     [2][NUM_ENTRIES][MAX_LEN];
  logic [OFFW-1:0] len_tab [2][NUM_ENTRIES];
  logic [IDXW-1:0] ent;

  for (genvar gb = 0; gb < 2; gb++) begin : g_bank
    for (genvar ge = 0; ge < NUM_ENTRIES; ge++) begin : g_ent
      assign len_tab[gb][ge] = OFFW'(item_len_f(gb, ge, MAX_LEN));
      for (genvar gk = 0; gk < MAX_LEN; gk++) begin : g_byte
        assign mem[gb][ge][gk] = item_byte_f(gb, ge, gk, DMA_PRESENT);
      end
    end
  end

  assign ent   = (int'(idx_i) < NUM_ENTRIES) ? idx_i : '0;
  assign len_o = len_tab[bank_i][ent];

  for (genvar gj = 0; gj < LANES; gj++) begin : g_lane
    int unsigned pos;
    always_comb begin
      pos = int'(off_i) + gj;
      lane_o[gj] = (pos < MAX_LEN) ? mem[bank_i][ent][ADRW'(pos)] : 8'h00;
    end
  end
endmodule

// File: rtl/cfg_sel_state.sv
module cfg_sel_state
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned IDXW        = 3,
  parameter int unsigned OFFW        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we_i,
  input  logic             sel_bank_i,
  input  logic [IDX_W-1:0] sel_index_i,
  input  logic [3:0]       adv_i,
  output logic             bank_o,
  output logic [IDXW-1:0]  idx_o,
  output logic             ok_o,
  output logic [OFFW-1:0]  off_o
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_ENTRIES);

  logic            bank_q, bank_n;
  logic [IDXW-1:0] idx_q, idx_n;
  logic            ok_q, ok_n;
  logic [OFFW-1:0] off_q, off_n;
  logic            upd_en;

  always_comb begin
    bank_n = bank_q;
    idx_n  = idx_q;
    ok_n   = ok_q;
    off_n  = off_q + OFFW'(adv_i);
    if (sel_we_i) begin
      bank_n = sel_bank_i;
      ok_n   = (sel_index_i < LIMIT);
      idx_n  = ok_n ? sel_index_i[IDXW-1:0] : '0;
      off_n  = '0;
    end
  end

  assign upd_en = sel_we_i | (adv_i != 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      idx_q  <= '0;
      ok_q   <= 1'b1;
      off_q  <= '0;
    end else if (upd_en) begin
      bank_q <= bank_n;
      idx_q  <= idx_n;
      ok_q   <= ok_n;
      off_q  <= off_n;
    end
  end

  assign bank_o = bank_q;
  assign idx_o  = idx_q;
  assign ok_o   = ok_q;
  assign off_o  = off_q;
endmodule

// File: rtl/cfg_read_pack.sv
module cfg_read_pack
  import cfg_port_pkg::*;
#(
  parameter int unsigned OFFW = 5
) (
  input  logic                  rd_en_i,
  input  logic [3:0]            size_i,
  input  logic                  ok_i,
  input  logic [OFFW-1:0]       off_i,
  input  logic [OFFW-1:0]       len_i,
  input  logic [LANES-1:0][7:0] lane_i,
  output logic [DATA_W-1:0]     data_o,
  output logic [3:0]            adv_o
);
  int unsigned avail, take, sz;

  always_comb begin
    sz    = int'(size_i);
    avail = (ok_i && (off_i < len_i)) ? int'(len_i - off_i) : 0;
    take  = 0;
    if (rd_en_i) take = (sz < avail) ? sz : avail;
    data_o = '0;
    for (int j = 0; j < LANES; j++) begin
      if (j < take) data_o[8*(sz-1-j) +: 8] = lane_i[j];
    end
    adv_o = 4'(take);
  end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned MAX_LEN     = 16,
  parameter bit          DMA_PRESENT = 1'b1,
  parameter bit          COMBINED    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic              acc_addr,
  input  logic [3:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned IDXW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int unsigned OFFW = $clog2(MAX_LEN + 1);

  logic                  data_rd, sel_wr;
  logic                  st_bank, st_ok;
  logic [IDXW-1:0]       st_idx;
  logic [OFFW-1:0]       st_off, item_len;
  logic [LANES-1:0][7:0] lanes;
  logic [3:0]            adv;
  logic                  unused_wdata;

  assign unused_wdata = ^{acc_wdata[DATA_W-1:KEY_W], acc_wdata[IDX_W]};

  if (COMBINED) begin : g_combined
    logic unused_addr;
    assign unused_addr = acc_addr;
    assign data_rd = acc_en && !acc_we && (acc_size == 4'd1);
    assign sel_wr  = acc_en &&  acc_we && (acc_size == 4'd2);
  end else begin : g_split
    logic size_ok;
    assign size_ok = (acc_size >= 4'd1) && (acc_size <= 4'd8);
    assign data_rd = acc_en && !acc_we &&  acc_addr && size_ok;
    assign sel_wr  = acc_en &&  acc_we && !acc_addr && (acc_size == 4'd2);
  end

  cfg_sel_state #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDXW(IDXW), .OFFW(OFFW)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_we_i   (sel_wr),
    .sel_bank_i (acc_wdata[BANK_BIT]),
    .sel_index_i(acc_wdata[IDX_W-1:0]),
    .adv_i      (adv),
    .bank_o     (st_bank),
    .idx_o      (st_idx),
    .ok_o       (st_ok),
    .off_o      (st_off)
  );

  cfg_item_rom #(
    .NUM_ENTRIES(NUM_ENTRIES), .MAX_LEN(MAX_LEN), .DMA_PRESENT(DMA_PRESENT),
    .IDXW(IDXW), .OFFW(OFFW)
  ) u_rom (
    .bank_i(st_bank),
    .idx_i (st_idx),
    .off_i (st_off),
    .len_o (item_len),
    .lane_o(lanes)
  );

  cfg_read_pack #(.OFFW(OFFW)) u_pack (
    .rd_en_i(data_rd),
    .size_i (acc_size),
    .ok_i   (st_ok),
    .off_i  (st_off),
    .len_i  (item_len),
    .lane_i (lanes),
    .data_o (rd_data),
    .adv_o  (adv)
  );
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
  parameter int unsigned IDXW = 3,
  parameter int unsigned OFFW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_en,
  input logic            acc_we,
  input logic [63:0]     rd_data,
  input logic            sel_wr,
  input logic            ok,
  input logic            bank,
  input logic [IDXW-1:0] idx,
  input logic [OFFW-1:0] off,
  input logic [OFFW-1:0] len
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (off == '0 && ok && !bank && idx == '0)
        else $error("reset state wrong");
    end
  end

  // R2
  cursor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (off == '0));

  // R6
  cursor_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (off <= len));

  // R4
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |-> (rd_data == 64'd0));

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |-> (rd_data == 64'd0));

  // R8
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && !sel_wr) |=>
      ($stable(off) && $stable(ok) && $stable(bank) && $stable(idx)));
endmodule

bind cfg_item_port cfg_item_port_chk #(.IDXW(IDXW), .OFFW(OFFW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .acc_en (acc_en),
  .acc_we (acc_we),
  .rd_data(rd_data),
  .sel_wr (sel_wr),
  .ok     (st_ok),
  .bank   (st_bank),
  .idx    (st_idx),
  .off    (st_off),
  .len    (item_len)
);

// File: tb/tb_cfg_item_port.sv
module tb_cfg_item_port;
  localparam int NE   = 8;
  localparam int MLEN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        acc_en = 1'b0, acc_we = 1'b0, acc_addr = 1'b0;
  logic [3:0]  acc_size = 4'd0;
  logic [63:0] acc_wdata = 64'd0;
  logic [63:0] rd_s, rd_c;

  int total = 0, bad = 0;
  bit done = 0;

  // model state, index 0 = split map, 1 = combined map
  int m_bank[2], m_idx[2], m_off[2];
  bit m_ok[2];

  always #5 clk = ~clk;

  cfg_item_port #(.NUM_ENTRIES(NE), .MAX_LEN(MLEN), .DMA_PRESENT(1'b1), .COMBINED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .rd_data(rd_s));

  cfg_item_port #(.NUM_ENTRIES(NE), .MAX_LEN(MLEN), .DMA_PRESENT(1'b1), .COMBINED(1'b1)) dut_comb (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .rd_data(rd_c));

  // R11 / R10 / R1 item definitions
  function automatic int ref_len(int b, int i);
    if (b == 0 && (i == 0 || i == 1)) return 4;
    return (5 * i + 12 * b) % (MLEN + 1);
  endfunction

  function automatic logic [7:0] ref_byte(int b, int i, int k);
    logic [31:0] sig = "CFGP";
    logic [7:0]  v;
    if (b == 0 && i == 0) return sig[8*(3-k) +: 8];
    if (b == 0 && i == 1) return (k == 0) ? 8'h03 : 8'h00;
    v = 8'(i * 16) ^ 8'(k * 7);
    if (b == 1) v = v ^ 8'hA5;
    return v;
  endfunction

  function automatic bit is_rd(int m, logic we, logic ad, int sz);
    if (m == 1) return !we && sz == 1;
    return !we && ad && sz >= 1 && sz <= 8;
  endfunction

  function automatic bit is_sel(int m, logic we, logic ad, int sz);
    if (m == 1) return we && sz == 2;
    return we && !ad && sz == 2;
  endfunction

  function automatic logic [63:0] model_step(int m, logic we, logic ad, int sz, logic [63:0] wd);
    logic [63:0] v = 64'd0;
    int cnt = 0;
    if (is_rd(m, we, ad, sz)) begin
      for (int j = 0; j < sz; j++) begin
        if (m_ok[m] && (m_off[m] + j) < ref_len(m_bank[m], m_idx[m])) begin
          v[8*(sz-1-j) +: 8] = ref_byte(m_bank[m], m_idx[m], m_off[m] + j);
          cnt++;
        end
      end
      m_off[m] += cnt;
    end else if (is_sel(m, we, ad, sz)) begin
      m_bank[m] = int'(wd[15]);
      m_idx[m]  = int'(wd[13:0]);
      m_ok[m]   = m_idx[m] < NE;
      m_off[m]  = 0;
    end
    return v;
  endfunction

  task automatic check(string tag, string who, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, who, act, exp);
    end
  endtask

  task automatic acc(string tag, logic we, logic ad, int sz, logic [63:0] wd);
    logic [63:0] es, ec;
    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_addr = ad; acc_size = 4'(sz); acc_wdata = wd;
    #4;
    es = model_step(0, we, ad, sz, wd);
    ec = model_step(1, we, ad, sz, wd);
    check(tag, "split", rd_s, es);
    check(tag, "comb", rd_c, ec);
  endtask

  task automatic idle_check();
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0; acc_size = 4'd1; acc_addr = 1'b1;
    #4;
    check("R12", "split", rd_s, 64'd0);
    check("R12", "comb", rd_c, 64'd0);
  endtask

  // select on both maps: split needs addr 0
  task automatic sel(string tag, logic [15:0] key);
    acc(tag, 1'b1, 1'b0, 2, {48'd0, key});
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_bank[m] = 0; m_idx[m] = 0; m_off[m] = 0; m_ok[m] = 1;
    end
    void'($urandom(32'd2718));
    #1 rst_n = 1'b0;
    #20;
    @(negedge clk) rst_n = 1'b1;

    // R1 signature after reset (split reads 4, combined ignores size 4)
    acc("R1", 1'b0, 1'b1, 4, 64'd0);
    for (int k = 0; k < 4; k++) acc("R1", 1'b0, 1'b1, 1, 64'd0);
    idle_check();

    // R10 version item
    sel("R2", 16'h0001);
    acc("R10", 1'b0, 1'b1, 4, 64'd0);
    // R2 reselect clears cursor even after partial read
    sel("R2", 16'h0001);
    acc("R2", 1'b0, 1'b1, 1, 64'd0);

    // R6 short item padded (common bank index 7, length 1)
    sel("R6", 16'h0007);
    acc("R6", 1'b0, 1'b1, 8, 64'd0);
    acc("R7", 1'b0, 1'b1, 2, 64'd0);

    // R7 empty item (local bank index 1)
    sel("R7", 16'h8001);
    acc("R7", 1'b0, 1'b1, 1, 64'd0);

    // R4 invalid indices, R2 cursor cleared on invalid key too
    sel("R4", 16'h0008);
    acc("R4", 1'b0, 1'b1, 8, 64'd0);
    sel("R4", 16'h3FFF);
    acc("R4", 1'b0, 1'b1, 1, 64'd0);

    // R3 bit 14 ignored, bank bit honoured
    sel("R3", 16'h4003);
    acc("R3", 1'b0, 1'b1, 2, 64'd0);
    sel("R3", 16'hC003);
    acc("R3", 1'b0, 1'b1, 3, 64'd0);

    // R8 data writes have no effect
    acc("R8", 1'b1, 1'b1, 1, 64'hFFFF_FFFF_FFFF_8002);
    acc("R8", 1'b1, 1'b1, 4, 64'h0000_0000_0000_0005);
    acc("R8", 1'b0, 1'b1, 1, 64'd0);

    // R9 odd control accesses ignored
    acc("R9", 1'b1, 1'b0, 4, 64'h0000_0000_0000_0002);
    acc("R9", 1'b1, 1'b0, 1, 64'h0000_0000_0000_0002);
    acc("R9", 1'b0, 1'b0, 2, 64'd0);
    acc("R9", 1'b0, 1'b1, 1, 64'd0);

    // R5 full-width reads on a long item (common bank index 3, length 15)
    sel("R5", 16'h0003);
    acc("R5", 1'b0, 1'b1, 8, 64'd0);
    acc("R6", 1'b0, 1'b1, 8, 64'd0);

    // random mix
    for (int n = 0; n < 2500; n++) begin
      int op;
      int sz;
      logic [15:0] key;
      op = int'($urandom % 10);
      sz = int'($urandom % 10);
      key = {1'($urandom), 1'($urandom), 14'($urandom % 11)};
      if (op < 2) sel("R2 R3 R4", key);
      else if (op < 7) acc("R5 R6 R7", 1'b0, 1'($urandom), (op < 5) ? 1 : sz, 64'd0);
      else if (op < 9) acc("R8 R9", 1'b1, 1'($urandom), sz, {$urandom, $urandom});
      else idle_check();
    end

    @(negedge clk) acc_en = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule